// File: doc/BRIEF.md
# Packed Run-Length Capture Stream Decoder

This block turns the packed contents of a logic-analyser capture memory into a plain stream of 34-channel samples. Memory words arrive 32 bits at a time, grouped into slices of nine words. Each slice carries eight 36-bit entries. The first eight words hold the low 32 bits of the eight entries. The ninth word packs the upper four bits of all eight entries, one nibble per entry.

Each entry is decoded by a two-state machine. A data entry carries a sample, a repeat bit and a flag. The flag announces that the next entry is a run-length extension. The block expands each run into one sample per accepted output handshake.

Software-side logic loads a valid entry count and a sample limit with a start pulse. The block then pulls slices from the input port until the valid entries are used up. Trailing pad entries in the last slice are thrown away. Output is cut off at the programmed limit, and the sample that reaches the limit is flagged as the last one.

Top module: `rle_slice_decoder`

## Requirements
- R1: After reset and before the first start pulse, in_ready_o, out_valid_o and done_o are all low.
- R2: A slice is nine input words. Words 0 to 7 give bits 31:0 of entries 0 to 7. Word 8 bits [31-4i:28-4i] give bits 35:32 of entry i, so entry 0 takes bits 31:28 and entry 7 takes bits 3:0. An emitted sample is entry bits 33:0.
- R3: A data entry sets a run of (bit 34 + 1) copies of its sample, so the run is 1 or 2.
- R4: When bit 35 of a data entry is 1, the next entry is a length entry. Twice its full 36-bit value is added to the pending run. The run is emitted only after that length entry has been absorbed, even when the length entry lies in the next slice. Decoding then returns to the data state.
- R5: Only the first word_count_i entries are decoded, and entries past that count are ignored. The input accepts exactly ceil(word_count_i/8) slices, and nothing more.
- R6: No more than sample_limit_i samples are emitted, and a run is cut short to fit. out_last_o is high with the sample that reaches the limit. A limit of 0 emits nothing.
- R7: When the valid entries end on a flagged data entry with no length entry after it, its base run (1 or 2) is still emitted.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_sample_o holds its value.
- R9: No new entry is consumed while a run is still being emitted. The decoder state, the held sample and the run count carry across slice boundaries and input gaps.
- R10: done_o rises in either of two cases: the valid entries are used up and the last run has been emitted, or the limit is reached. It stays high until the next start pulse. While done_o is high, in_ready_o and out_valid_o are low.
- R11: start_i clears all decoder state and loads word_count_i and sample_limit_i. in_ready_o is low in the start cycle, and out_valid_o is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that clears state and loads count and limit |
| word_count_i | input | 16 | Number of valid entries in the stream |
| sample_limit_i | input | 32 | Maximum number of samples to emit |
| in_data_i | input | 32 | Packed memory word |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted on this edge when valid |
| out_sample_o | output | 34 | Decoded channel sample |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Consumer accepts output sample |
| out_last_o | output | 1 | Sample that reaches the limit |
| done_o | output | 1 | Stream finished or limit reached |

## Verification
The hardest case to reach from the ports is a flagged data entry in the last position of a slice. Its length entry then only arrives after nine more input words, and the pending run must stay held back across that gap. Directed stimulus places a flagged entry at position 7 with its length entry in the next slice. The random slices also let flags fall on slice edges, while the input valid and output ready signals gap at random. Two further directed cases cover a length entry whose upper nibble makes the run huge, cut short by a small limit, and a stream that ends on a flagged entry with no length entry following.

// File: rtl/rle_dec_pkg.sv
package rle_dec_pkg;
  typedef enum logic {DEC_DATA = 1'b0, DEC_LEN = 1'b1} dec_st_e;
  typedef enum logic {SB_LOAD = 1'b0, SB_DRAIN = 1'b1} sb_st_e;
endpackage

// File: rtl/rle_slice_unpack.sv
module rle_slice_unpack
  import rle_dec_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ENT_W     = 36,
  parameter int SLICE_ENT = 8,
  parameter int CNT_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [ENT_W-1:0]  ent_o,
  output logic              ent_valid_o,
  input  logic              ent_ready_i,
  output logic              exhausted_o
);
  localparam int HI_W  = ENT_W - WORD_W;
  localparam int IDX_W = $clog2(SLICE_ENT + 1);
  localparam int POS_W = $clog2(SLICE_ENT);
  localparam int SH    = $clog2(SLICE_ENT);

  sb_st_e            st_q;
  logic [IDX_W-1:0]  widx_q;
  logic [POS_W-1:0]  pos_q;
  logic [WORD_W-1:0] low_q [SLICE_ENT];
  logic [WORD_W-1:0] hi_q;
  logic [CNT_W-1:0]  slices_left_q;
  logic [CNT_W-1:0]  ents_left_q;
  logic [HI_W-1:0]   hi_nib [SLICE_ENT];
  logic [CNT_W:0]    cnt_sum;
  logic              in_fire, ent_fire;

  // entry 0 owns the top nibble of the shared word
  for (genvar g = 0; g < SLICE_ENT; g++) begin : g_nib
    assign hi_nib[g] = hi_q[WORD_W-1-HI_W*g -: HI_W];
  end

  assign cnt_sum     = {1'b0, count_i} + (CNT_W+1)'(SLICE_ENT - 1);
  assign in_ready_o  = (st_q == SB_LOAD) && (slices_left_q != '0) && !clear_i;
  assign in_fire     = in_valid_i && in_ready_o;
  assign ent_valid_o = (st_q == SB_DRAIN) && (ents_left_q != '0) && !clear_i;
  assign ent_fire    = ent_valid_o && ent_ready_i;
  assign ent_o       = {hi_nib[pos_q], low_q[pos_q]};
  assign exhausted_o = (ents_left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= SB_LOAD;
      widx_q        <= '0;
      pos_q         <= '0;
      hi_q          <= '0;
      slices_left_q <= '0;
      ents_left_q   <= '0;
      for (int i = 0; i < SLICE_ENT; i++) low_q[i] <= '0;
    end else if (clear_i) begin
      st_q          <= SB_LOAD;
      widx_q        <= '0;
      pos_q         <= '0;
      slices_left_q <= CNT_W'(cnt_sum >> SH);
      ents_left_q   <= count_i;
    end else if (st_q == SB_LOAD) begin
      if (in_fire) begin
        if (widx_q == IDX_W'(SLICE_ENT)) begin
          hi_q          <= in_data_i;
          widx_q        <= '0;
          pos_q         <= '0;
          st_q          <= SB_DRAIN;
          slices_left_q <= slices_left_q - 1'b1;
        end else begin
          low_q[widx_q[POS_W-1:0]] <= in_data_i;
          widx_q <= widx_q + 1'b1;
        end
      end
    end else begin
      if (ents_left_q == '0) begin
        st_q <= SB_LOAD;
      end else if (ent_fire) begin
        ents_left_q <= ents_left_q - 1'b1;
        if (pos_q == POS_W'(SLICE_ENT - 1) || ents_left_q == CNT_W'(1)) st_q <= SB_LOAD;
        else pos_q <= pos_q + 1'b1;
      end
    end
  end

  p_exhaust_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exhausted_o && !clear_i) |=> exhausted_o);
  p_slice_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slices_left_q == '0 && !clear_i) |=> (slices_left_q == '0));
endmodule

// File: rtl/rle_run_engine.sv
module rle_run_engine
  import rle_dec_pkg::*;
#(
  parameter int CH_W  = 34,
  parameter int ENT_W = 36,
  parameter int RUN_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             halt_i,
  input  logic [ENT_W-1:0] ent_i,
  input  logic             ent_valid_i,
  output logic             ent_ready_o,
  input  logic             exhausted_i,
  output logic [CH_W-1:0]  out_sample_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             idle_o
);
  localparam int REP_BIT = CH_W;
  localparam int LEN_BIT = CH_W + 1;

  dec_st_e          st_q;
  logic [RUN_W-1:0] run_q;
  logic [CH_W-1:0]  sample_q;
  logic [RUN_W-1:0] len_ext;
  logic             ent_fire, out_fire;

  assign len_ext      = RUN_W'({ent_i, 1'b0});
  // a data entry waits for its run to drain; a length entry is absorbed at once
  assign ent_ready_o  = !halt_i && ((st_q == DEC_DATA && run_q == '0) || st_q == DEC_LEN);
  assign out_valid_o  = !halt_i && (run_q != '0) && (st_q == DEC_DATA || exhausted_i);
  assign ent_fire     = ent_valid_i && ent_ready_o;
  assign out_fire     = out_valid_o && out_ready_i;
  assign out_sample_o = sample_q;
  assign idle_o       = (run_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= DEC_DATA;
      run_q    <= '0;
      sample_q <= '0;
    end else if (clear_i) begin
      st_q     <= DEC_DATA;
      run_q    <= '0;
      sample_q <= '0;
    end else if (ent_fire) begin
      if (st_q == DEC_DATA) begin
        sample_q <= ent_i[CH_W-1:0];
        run_q    <= RUN_W'(ent_i[REP_BIT]) + RUN_W'(1);
        st_q     <= ent_i[LEN_BIT] ? DEC_LEN : DEC_DATA;
      end else begin
        run_q <= run_q + len_ext;
        st_q  <= DEC_DATA;
      end
    end else if (out_fire) begin
      run_q <= run_q - 1'b1;
    end
  end

  p_data_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (ent_fire && st_q == DEC_DATA) |=>
      (sample_q == $past(ent_i[CH_W-1:0])) &&
      (run_q == RUN_W'($past(ent_i[REP_BIT])) + RUN_W'(1)));
  p_len_add_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (ent_fire && st_q == DEC_LEN) |=>
      (run_q == $past(run_q) + RUN_W'({$past(ent_i), 1'b0})) && (st_q == DEC_DATA));
  p_no_grab_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (out_valid_o && !out_ready_i) |=> $stable(sample_q));
endmodule

// File: rtl/rle_limit_ctr.sv
module rle_limit_ctr #(
  parameter int LIM_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             fire_i,
  output logic             hit_o,
  output logic             last_o
);
  logic [LIM_W-1:0] cnt_q, lim_q;

  assign hit_o  = (cnt_q == lim_q);
  assign last_o = (({1'b0, cnt_q} + (LIM_W+1)'(1)) == {1'b0, lim_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (fire_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  p_last_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (fire_i && last_o) |=> hit_o);
endmodule

// File: rtl/rle_slice_decoder.sv
module rle_slice_decoder #(
  parameter int WORD_W    = 32,
  parameter int CH_W      = 34,
  parameter int SLICE_ENT = 8,
  parameter int CNT_W     = 16,
  parameter int LIM_W     = 32,
  parameter int RUN_W     = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  word_count_i,
  input  logic [LIM_W-1:0]  sample_limit_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [CH_W-1:0]   out_sample_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_last_o,
  output logic              done_o
);
  localparam int ENT_W = CH_W + 2;

  logic [ENT_W-1:0] ent;
  logic ent_valid, ent_ready, exhausted, idle;
  logic sb_in_ready, lim_hit, lim_last, armed_q;

  rle_slice_unpack #(
    .WORD_W(WORD_W), .ENT_W(ENT_W), .SLICE_ENT(SLICE_ENT), .CNT_W(CNT_W)
  ) u_unpack (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i), .count_i(word_count_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i && !done_o), .in_ready_o(sb_in_ready),
    .ent_o(ent), .ent_valid_o(ent_valid), .ent_ready_i(ent_ready), .exhausted_o(exhausted)
  );

  rle_run_engine #(
    .CH_W(CH_W), .ENT_W(ENT_W), .RUN_W(RUN_W)
  ) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i), .halt_i(lim_hit),
    .ent_i(ent), .ent_valid_i(ent_valid), .ent_ready_o(ent_ready), .exhausted_i(exhausted),
    .out_sample_o(out_sample_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .idle_o(idle)
  );

  rle_limit_ctr #(
    .LIM_W(LIM_W)
  ) u_limit (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i), .limit_i(sample_limit_i),
    .fire_i(out_valid_o && out_ready_i), .hit_o(lim_hit), .last_o(lim_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (start_i) armed_q <= 1'b1;
  end

  assign done_o     = armed_q && (lim_hit || (exhausted && idle));
  assign in_ready_o = sb_in_ready && !done_o;
  assign out_last_o = out_valid_o && lim_last;

  p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  p_done_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!in_ready_o && !out_valid_o));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || start_i)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_sample_o)));
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !out_valid_o);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (!in_ready_o && !out_valid_o && !done_o));
endmodule

// File: tb/rle_slice_decoder_tb.sv
module rle_slice_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] word_count_i = '0;
  logic [31:0] sample_limit_i = '0;
  logic [31:0] in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [33:0] out_sample_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic        out_last_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [35:0] ent_arr [0:255];
  logic [33:0] exp_q [$];

  always #4 clk_i = ~clk_i;

  rle_slice_decoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .word_count_i(word_count_i),
    .sample_limit_i(sample_limit_i), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .out_sample_o(out_sample_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_last_o(out_last_o), .done_o(done_o)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(int wi);
    int s = wi / 9;
    int w = wi % 9;
    logic [31:0] r = '0;
    if (w < 8) return ent_arr[s*8+w][31:0];
    for (int j = 0; j < 8; j++) r[31-4*j -: 4] = ent_arr[s*8+j][35:32];
    return r;
  endfunction

  task automatic push_run(logic [33:0] s, longint n, int lim);
    for (longint k = 0; k < n && exp_q.size() < lim; k++) exp_q.push_back(s);
  endtask

  // reference model: sequential two-state decode, then truncation to the limit
  task automatic build_expected(int cnt, int lim);
    bit in_len = 0;
    longint pend = 0;
    logic [33:0] s = '0;
    exp_q.delete();
    for (int i = 0; i < cnt; i++) begin
      if (!in_len) begin
        push_run(s, pend, lim);
        s = ent_arr[i][33:0];
        pend = longint'(ent_arr[i][34]) + 1;
        in_len = ent_arr[i][35];
      end else begin
        pend += longint'(ent_arr[i]) * 2;
        in_len = 0;
      end
    end
    push_run(s, pend, lim);
  endtask

  task automatic gen_random(int n);
    int i = 0;
    while (i < n) begin
      ent_arr[i] = {($urandom % 4 == 0), 1'($urandom), 2'($urandom), 32'($urandom)};
      i++;
      if (ent_arr[i-1][35] && i < n) begin
        ent_arr[i] = 36'($urandom % 12);
        i++;
      end
    end
  endtask

  task automatic run_test(string req, int cnt, int lim);
    int total = ((cnt + 7) / 8) * 9;
    int got = 0;
    for (int i = cnt; i < ((cnt + 7) / 8) * 8; i++)
      ent_arr[i] = {4'($urandom), 32'($urandom)};
    build_expected(cnt, lim);
    @(negedge clk_i);
    word_count_i = 16'(cnt);
    sample_limit_i = 32'(lim);
    start_i = 1'b1;
    #1 chk(!in_ready_o, "R11", "in_ready during start", longint'(in_ready_o), 0);
    @(negedge clk_i);
    start_i = 1'b0;
    fork
      begin : drv
        int wi = 0;
        while (wi < total) begin
          @(negedge clk_i);
          if ($urandom % 4 == 0) in_valid_i = 1'b0;
          else begin in_valid_i = 1'b1; in_data_i = word_at(wi); end
          #1;
          if (done_o) break;
          if (in_valid_i && in_ready_o) wi++;
        end
        @(negedge clk_i);
        in_valid_i = 1'b0;
      end
      begin : mon
        bit stalled = 0;
        logic [33:0] prev = '0;
        forever begin
          @(negedge clk_i);
          if (stalled)
            chk(out_valid_o && out_sample_o == prev, "R8", "stall hold",
                longint'(out_sample_o), longint'(prev));
          out_ready_i = ($urandom % 10 < 7);
          #1;
          if (out_valid_o && out_ready_i) begin
            if (got < exp_q.size()) begin
              chk(out_sample_o == exp_q[got], req, "sample", longint'(out_sample_o),
                  longint'(exp_q[got]));
              chk(out_last_o == (got + 1 == lim), "R6", "last flag",
                  longint'(out_last_o), longint'(got + 1 == lim));
            end else chk(0, req, "extra sample", got, exp_q.size());
            got++;
          end
          stalled = out_valid_o && !out_ready_i;
          prev = out_sample_o;
          if (done_o && !out_valid_o) break;
        end
        out_ready_i = 1'b0;
      end
    join
    chk(got == exp_q.size(), req, "sample count", got, exp_q.size());
    repeat (3) @(negedge clk_i);
    #1;
    chk(done_o, "R10", "done held", longint'(done_o), 1);
    chk(!in_ready_o && !out_valid_o, "R10", "quiet after done",
        longint'({in_ready_o, out_valid_o}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int tot;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    #1;
    chk(!in_ready_o && !out_valid_o && !done_o, "R1", "reset outputs",
        longint'({in_ready_o, out_valid_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1;
    chk(!in_ready_o && !out_valid_o && !done_o, "R1", "idle before start",
        longint'({in_ready_o, out_valid_o, done_o}), 0);

    // R2 R3: nibble mapping, alternating repeat bit
    for (int i = 0; i < 8; i++)
      ent_arr[i] = {1'b0, 1'(i), 2'(i), 32'hA000_0000 + 32'(i * 32'h111)};
    run_test("R2", 8, 1000);

    // R4: flagged entry at slot 7, length entry in the next slice
    gen_random(7);
    for (int i = 0; i < 7; i++) ent_arr[i][35] = 1'b0;
    ent_arr[7] = {2'b11, 34'h2_DEAD_BEEF};
    ent_arr[8] = 36'd3;
    for (int i = 9; i < 12; i++) ent_arr[i] = {2'b00, 2'($urandom), 32'($urandom)};
    run_test("R4", 12, 1000);

    // R5: count not a slice multiple, trailing garbage
    gen_random(5);
    run_test("R5", 5, 1000);

    // R7: stream ends on flagged entry
    ent_arr[0] = {2'b01, 34'h1_1111_1111};
    ent_arr[1] = {2'b00, 34'h2_2222_2222};
    ent_arr[2] = {2'b10, 34'h3_3333_3333};
    run_test("R7", 3, 1000);

    // R6: huge run from high-nibble length, cut by limit
    ent_arr[0] = {2'b10, 34'h0_CAFE_0001};
    ent_arr[1] = 36'h1_0000_0000;
    run_test("R6", 2, 9);

    // R6: limit zero
    gen_random(4);
    run_test("R6", 4, 0);

    // R5 R10: empty stream
    run_test("R10", 0, 5);

    // R6: limit equal to total
    gen_random(16);
    build_expected(16, 1 << 30);
    tot = exp_q.size();
    run_test("R6", 16, tot);

    // R9 R11: random streams with gaps, back-to-back restarts
    for (int t = 0; t < 20; t++) begin
      int c = 1 + int'($urandom % 60);
      int l = ($urandom % 2 == 0) ? 1000000 : 1 + int'($urandom % 40);
      gen_random(c);
      run_test("R9", c, l);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule